// File: doc/BRIEF.md
# Program Counter with Return Stack

This block holds the instruction address of a small 4-bit controller and decides, once per clock, where the next instruction comes from. The address is 10 bits wide. On sequential flow it moves forward by the length of the instruction just executed. A jump can load a new address in full, or replace only the low eight bits and keep the page bits. A call saves the address one past the current PC on a small hardware return stack and then branches. A return restores the saved address plus two.

The stack depth is tracked by a 2-bit stack pointer. Index 0 means empty. The pointer counts up on each accepted call and down on each accepted return. A call made with the pointer already at its top value is an overflow, and a return made with the pointer at zero is an underflow. Either one is treated as a controller fault. On a fault the block raises a one-cycle reset request, and on the following clock edge the PC and the stack pointer both go back to zero. Instruction decode and data memory belong to the surrounding controller.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the PC becomes 0, the stack pointer becomes 0 and `fault_o` becomes 0.
- R2: With only `adv_i` set, the PC becomes PC + `adv_len_i`, modulo 1024. A length of 0 and a cycle with no strobe both leave the PC unchanged.
- R3: A jump with `full_ld_i` = 1 loads all 10 bits of `tgt_i` into the PC.
- R4: A jump with `full_ld_i` = 0 loads `tgt_i[7:0]` into PC bits 7:0 and keeps PC bits 9:8.
- R5: An accepted call loads all 10 bits of `tgt_i` into the PC, saves PC + 1 (modulo 1024) in stack slot `sp`, and then increments the stack pointer.
- R6: An accepted return loads (slot `sp`-1) + 2, modulo 1024, into the PC and decrements the stack pointer. Saved entries come back in last-in, first-out order.
- R7: A call made while the stack pointer equals 3 is an overflow. The PC and stack pointer hold for that edge and `fault_o` is 1 for exactly one cycle. On the next edge the PC and stack pointer become 0, whatever the strobes are. At most three calls can therefore be nested.
- R8: A return made while the stack pointer equals 0 is an underflow. It behaves the same way as R7: the state holds, a one-cycle `fault_o` pulse follows, and then the PC and stack pointer are cleared.
- R9: When several strobes are set together, only one takes effect, in the priority order call, return, jump, advance. While `fault_o` is 1, every strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance by instruction length |
| adv_len_i | input | 2 | Instruction length in address units |
| jmp_i | input | 1 | Jump strobe |
| full_ld_i | input | 1 | Jump load width: 1 = all 10 bits, 0 = low 8 bits only |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| tgt_i | input | 10 | Jump or call destination |
| pc_o | output | 10 | Current program counter |
| sp_o | output | 2 | Current stack depth |
| fault_o | output | 1 | One-cycle internal reset request after an overflow or underflow |

## Verification
The directed sequences cover each way the PC can change:
- every advance length, including zero;
- a wrap past 3FFh;
- full and partial jumps from a page other than zero, so that keeping bits 9:8 can be told apart from loading them;
- three nested calls followed by three returns, so that the LIFO order and the +2 offset are both visible.

Overflow and underflow are each provoked and then followed by strobes during the pulse, which separates holding from acting early and shows that the clear is forced. Seeded random stimulus mixes all strobes, often several at a time, so the priority order is exercised at every stack depth against a bench model.

// File: rtl/pcs_pkg.sv
// Shared types for the program counter and return stack.
// Assumes: one operation is selected per clock by pcs_arbiter.
package pcs_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_ADV   = 3'd1,
        OP_JMP   = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_FLUSH = 3'd5
    } pc_op_e;
endpackage

// File: rtl/pcs_arbiter.sv
// Picks the single operation for this cycle from the raw strobes.
// Assumes: flush_i is the registered fault pulse and outranks all strobes.
module pcs_arbiter
    import pcs_pkg::*;
(
    input  logic   flush_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   jmp_i,
    input  logic   adv_i,
    output pc_op_e op_o
);
    // Fixed priority: flush, call, return, jump, advance.
    always_comb begin
        if (flush_i)     op_o = OP_FLUSH;
        else if (call_i) op_o = OP_CALL;
        else if (ret_i)  op_o = OP_RET;
        else if (jmp_i)  op_o = OP_JMP;
        else if (adv_i)  op_o = OP_ADV;
        else             op_o = OP_HOLD;
    end

    // R9: the flush pulse wins over every strobe
    always_comb begin
        if (flush_i) assert_flush_wins_R9: assert (op_o == OP_FLUSH);
    end
endmodule

// File: rtl/pcs_stack.sv
// Return stack with its depth pointer and overflow/underflow fault pulse.
// Assumes: a push writes the slot at the current pointer, and a pop reads
// slot pointer-1. The top pointer value is never written, so only
// 2**SP_W - 1 slots exist.
module pcs_stack
    import pcs_pkg::*;
#(
    parameter int PC_W = 10,
    parameter int SP_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_op_e          op_i,
    input  logic [PC_W-1:0] push_data_i,
    output logic [SP_W-1:0] sp_o,
    output logic [PC_W-1:0] top_o,
    output logic            block_o,
    output logic            fault_o
);
    localparam int              SLOTS   = (1 << SP_W) - 1;
    localparam logic [SP_W-1:0] SP_FULL = SP_W'(SLOTS);

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_dn;
    logic            fault_q;
    logic [PC_W-1:0] slot_q [SLOTS];
    logic            push_ok;
    logic            pop_ok;

    // An overflowing call or an underflowing return is refused.
    always_comb begin
        block_o = ((op_i == OP_CALL) && (sp_q == SP_FULL)) ||
                  ((op_i == OP_RET)  && (sp_q == '0));
        push_ok = (op_i == OP_CALL) && !block_o;
        pop_ok  = (op_i == OP_RET)  && !block_o;
        sp_dn   = sp_q - SP_W'(1);
    end

    // Depth pointer: cleared on reset or flush, stepped on accepted push/pop.
    always_ff @(posedge clk) begin
        if (!rst_n || op_i == OP_FLUSH) sp_q <= '0;
        else if (push_ok)               sp_q <= sp_q + SP_W'(1);
        else if (pop_ok)                sp_q <= sp_dn;
    end

    // Fault pulse: set for one cycle after a refused push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= block_o;
    end

    // One register per slot, written only when the push targets it.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && sp_q == SP_W'(g)) slot_q[g] <= push_data_i;
        end
    end

    // Top-of-stack read mux, indexed by pointer-1.
    always_comb begin
        top_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (sp_dn == SP_W'(i)) top_o = slot_q[i];
        end
    end

    assign sp_o    = sp_q;
    assign fault_o = fault_q;

    // R7: a call at full depth holds the pointer and raises the fault
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CALL && sp_q == SP_FULL) |=> (fault_o && sp_q == SP_FULL));
    // R8: a return at zero depth holds the pointer and raises the fault
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RET && sp_q == '0) |=> (fault_o && sp_q == '0));
    // R7: the fault pulse lasts exactly one cycle
    assert_fault_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);
    // R5: an accepted call deepens the stack by one
    assert_push_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CALL && sp_q != SP_FULL) |=> (sp_q == $past(sp_q) + SP_W'(1)));
endmodule

// File: rtl/pcs_pc.sv
// Program counter register and next-address selection.
// Assumes: op_i is a single operation from the arbiter, and block_i marks a
// refused call or return that must leave the PC unchanged.
module pcs_pc
    import pcs_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int LEN_W  = 2,
    parameter int PART_W = 8,
    parameter int RET_OFS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pc_op_e           op_i,
    input  logic             block_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [PC_W-1:0]  tgt_i,
    input  logic             full_ld_i,
    input  logic [PC_W-1:0]  ret_val_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  pc_inc_o
);
    localparam int HI_W = PC_W - PART_W;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] jmp_addr;

    // Jump target: a full load, or a low-field load that keeps the page bits.
    always_comb begin
        if (full_ld_i) jmp_addr = tgt_i;
        else           jmp_addr = {pc_q[PC_W-1:PART_W], tgt_i[PART_W-1:0]};
    end

    // Next-address selection for each operation.
    always_comb begin
        pc_d = pc_q;
        unique case (op_i)
            OP_ADV:   pc_d = pc_q + PC_W'(len_i);
            OP_JMP:   pc_d = jmp_addr;
            OP_CALL:  if (!block_i) pc_d = tgt_i;
            OP_RET:   if (!block_i) pc_d = ret_val_i + PC_W'(RET_OFS);
            OP_FLUSH: pc_d = '0;
            default:  pc_d = pc_q;
        endcase
    end

    // PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_o     = pc_q;
    assign pc_inc_o = pc_q + PC_W'(1);

    // R7/R8: the flush clears the PC on the next edge
    assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_FLUSH) |=> (pc_q == '0));
    // R6: an accepted return lands on the saved value plus the offset
    assert_ret_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RET && !block_i) |=> (pc_q == $past(ret_val_i) + PC_W'(RET_OFS)));
    // R4: a partial jump keeps the page bits
    assert_page_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_JMP && !full_ld_i) |=>
        (pc_q[PC_W-1:PC_W-HI_W] == $past(pc_q[PC_W-1:PC_W-HI_W])));
    // R7/R8: a refused call or return leaves the PC unchanged
    assert_block_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_CALL || op_i == OP_RET) && block_i) |=> $stable(pc_q));
endmodule

// File: rtl/pc_stack_unit.sv
// Top level: the program counter, the return stack and the strobe arbiter.
// Assumes: strobes are single-cycle and sampled at each rising edge, and
// reset is synchronous and active low.
module pc_stack_unit
    import pcs_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int SP_W   = 2,
    parameter int LEN_W  = 2,
    parameter int PART_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [LEN_W-1:0] adv_len_i,
    input  logic             jmp_i,
    input  logic             full_ld_i,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic [PC_W-1:0]  tgt_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             fault_o
);
    pc_op_e          op;
    logic            block;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] top_val;

    pcs_arbiter u_arb (
        .flush_i (fault_o),
        .call_i  (call_i),
        .ret_i   (ret_i),
        .jmp_i   (jmp_i),
        .adv_i   (adv_i),
        .op_o    (op)
    );

    pcs_stack #(.PC_W(PC_W), .SP_W(SP_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .push_data_i (pc_inc),
        .sp_o        (sp_o),
        .top_o       (top_val),
        .block_o     (block),
        .fault_o     (fault_o)
    );

    pcs_pc #(.PC_W(PC_W), .LEN_W(LEN_W), .PART_W(PART_W), .RET_OFS(2)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .block_i   (block),
        .len_i     (adv_len_i),
        .tgt_i     (tgt_i),
        .full_ld_i (full_ld_i),
        .ret_val_i (top_val),
        .pc_o      (pc_o),
        .pc_inc_o  (pc_inc)
    );

    // R1: reset leaves PC, pointer and fault at zero
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && sp_o == '0 && !fault_o));
    // R7: after the fault pulse the whole state is zero
    assert_fault_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (pc_o == '0 && sp_o == '0));
endmodule

// File: tb/pc_stack_unit_tb.sv
`timescale 1ns/1ps
module pc_stack_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv = 1'b0, jmp = 1'b0, call = 1'b0, ret = 1'b0, full = 1'b0;
    logic [1:0] len = '0;
    logic [9:0] tgt = '0;
    logic [9:0] pc;
    logic [1:0] sp;
    logic       flt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [9:0] m_pc = '0;
    int         m_sp = 0;
    logic [9:0] m_stk [3];
    logic       m_flt = 1'b0;

    always #2.5 clk = ~clk;

    pc_stack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .adv_len_i(len), .jmp_i(jmp),
        .full_ld_i(full), .call_i(call), .ret_i(ret), .tgt_i(tgt),
        .pc_o(pc), .sp_o(sp), .fault_o(flt)
    );

    // Requirement tag for the step about to be applied to the model.
    function automatic string tag_of();
        int n = int'(call) + int'(ret) + int'(jmp) + int'(adv);
        if (!rst_n) return "R1";
        if (m_flt)  return (n > 0) ? "R9" : "R7";
        if (n > 1)  return "R9";
        if (call)   return (m_sp == 3) ? "R7" : "R5";
        if (ret)    return (m_sp == 0) ? "R8" : "R6";
        if (jmp)    return full ? "R3" : "R4";
        return "R2";
    endfunction

    // Model update for one clock edge, from the requirements.
    task automatic model_step();
        if (!rst_n) begin
            m_pc = '0; m_sp = 0; m_flt = 1'b0;
        end else if (m_flt) begin
            m_pc = '0; m_sp = 0; m_flt = 1'b0;
        end else if (call) begin
            if (m_sp == 3) m_flt = 1'b1;
            else begin
                m_stk[m_sp] = m_pc + 10'd1;
                m_sp++;
                m_pc = tgt;
            end
        end else if (ret) begin
            if (m_sp == 0) m_flt = 1'b1;
            else begin
                m_sp--;
                m_pc = m_stk[m_sp] + 10'd2;
            end
        end else if (jmp) begin
            m_pc = full ? tgt : {m_pc[9:8], tgt[7:0]};
        end else if (adv) begin
            m_pc = m_pc + 10'(len);
        end
    endtask

    // Apply inputs after a falling edge, clock once, compare at the next falling edge.
    task automatic step(input logic a, input logic [1:0] l, input logic j,
                        input logic f, input logic c, input logic r,
                        input logic [9:0] t);
        string tg;
        adv = a; len = l; jmp = j; full = f; call = c; ret = r; tgt = t;
        tg = tag_of();
        @(posedge clk);
        model_step();
        @(negedge clk);
        n_chk++;
        if (pc !== m_pc || sp !== 2'(m_sp) || flt !== m_flt) begin
            n_bad++;
            $display("FAIL %s pc=%h sp=%0d flt=%b expected pc=%h sp=%0d flt=%b",
                     tg, pc, sp, flt, m_pc, m_sp, m_flt);
        end
        adv = 0; jmp = 0; call = 0; ret = 0;
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, '0); endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: reset state
        step(0, 0, 0, 0, 0, 0, '0);
        step(1, 3, 0, 0, 1, 0, 10'h155);
        rst_n = 1'b1;
        // R2: every advance length, and an empty cycle
        step(1, 1, 0, 0, 0, 0, '0);
        step(1, 2, 0, 0, 0, 0, '0);
        step(1, 3, 0, 0, 0, 0, '0);
        step(1, 0, 0, 0, 0, 0, '0);
        idle();
        // R3 full jump, then R4 partial jump from page 2
        step(0, 0, 1, 1, 0, 0, 10'h2A5);
        step(0, 0, 1, 0, 0, 0, 10'h15C);
        // R2 wrap past 3FF
        step(0, 0, 1, 1, 0, 0, 10'h3FF);
        step(1, 2, 0, 0, 0, 0, '0);
        // R5 three nested calls, R6 three returns in LIFO order
        step(0, 0, 0, 0, 1, 0, 10'h100);
        step(1, 3, 0, 0, 0, 0, '0);
        step(0, 0, 0, 0, 1, 0, 10'h200);
        step(0, 0, 0, 0, 1, 0, 10'h3FF);
        step(0, 0, 0, 0, 0, 1, '0);
        step(0, 0, 0, 0, 0, 1, '0);
        step(0, 0, 0, 0, 0, 1, '0);
        // R8 underflow, strobes ignored during the pulse (R9), then clear
        step(0, 0, 0, 0, 0, 1, '0);
        step(1, 1, 1, 1, 1, 1, 10'h3AA);
        // R7 overflow after three calls, pulse ignores a call
        step(0, 0, 1, 1, 0, 0, 10'h0F0);
        step(0, 0, 0, 0, 1, 0, 10'h011);
        step(0, 0, 0, 0, 1, 0, 10'h022);
        step(0, 0, 0, 0, 1, 0, 10'h033);
        step(0, 0, 0, 0, 1, 0, 10'h044);
        step(0, 0, 0, 0, 1, 0, 10'h055);
        // R9 priority: call over return, return over jump, jump over advance
        step(0, 0, 0, 0, 1, 1, 10'h123);
        step(0, 0, 1, 1, 0, 1, 10'h321);
        step(1, 3, 1, 1, 0, 0, 10'h0AB);
        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [9:0] t = 10'($urandom);
            logic [1:0] l = 2'($urandom);
            int         w = int'($urandom % 100);
            if (w < 2) begin
                rst_n = 1'b0;
                step(1, l, 0, 0, 0, 0, t);
                rst_n = 1'b1;
            end else begin
                step(($urandom % 100) < 60, l, ($urandom % 100) < 20,
                     1'($urandom), ($urandom % 100) < 15, ($urandom % 100) < 15, t);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule